// File: doc/BRIEF.md
# Pipelined Burst SRAM Cycle Controller

This block is the cycle controller and storage of a small pipelined synchronous burst memory with a 36-bit word. The word is split into four 9-bit byte lanes. On each rising clock edge it samples three chip enables, two address strobes, an advance input and the write qualifiers, which are a global write, a byte-write enable and four lane selects. From these it decides whether the edge is a deselect, a read, a write or an idle cycle. Writes go straight into an internal register array under a per-lane mask. Reads pass through one output register before they reach the data bus.

The two strobes behave differently. The processor strobe always opens a read. A write that follows it is taken on the next edge, with the write qualifiers sampled on that next edge. The controller strobe can write on the edge it is seen. After a strobe, a two-bit burst counter steps through the lower address bits in linear or interleaved order, one step for each edge on which the advance input is low. The block also drives the enable of the shared data bus. That enable is forced off after writes and deselects, and on the first cycle of a read that follows a deselect. It is also gated at once by an asynchronous, active-low output enable.

Top module: `burst_sram_core`

## Requirements
- R1: The block is selected only when `ce1_n`=0, `ce2`=1 and `ce3_n`=0 at a strobe edge. A strobe with any other enable combination is a deselect: nothing is written and `dq_oe` is 0 after that edge.
- R2: `adsp_n` is ignored while `ce1_n` is 1. With `adsc_n` also high the edge is a plain no-strobe cycle, so an open read burst continues and the address inputs are not captured.
- R3: A processor strobe (`adsp_n`=0, selected) always opens a read at `addr`, and the write inputs are ignored on that edge. On the next edge with no strobe and an active write qualifier, the word at the burst address is written with the qualifiers and data sampled on that next edge.
- R4: A controller strobe with `adsp_n`=1, the block selected and an active write qualifier writes `wdata` at `addr` on that same edge. When both strobes are low, only the processor strobe counts.
- R5: The write qualifier selects lanes as follows. `gw_n`=0 selects all four lanes. Otherwise, `bwe_n`=0 selects every lane i whose `bw_n[i]` is 0. Lane i is bits 9i+8..9i. With `bwe_n`=1, or with all selects at 1, nothing is written. Unselected lanes keep their contents, and any mix of selects is legal.
- R6: A read whose address is registered on edge k shows its word on `rdata`, with `dq_oe` at 1, after edge k+1.
- R7: The strobe loads the burst base. On a no-strobe cycle with `adv_n`=0, the counter steps before the access. The low two address bits are (base+step) mod 4 when `order_lin`=1 and base XOR step when `order_lin`=0, so they wrap within four words. With `adv_n`=1 the same address is accessed again.
- R8: After any write edge `dq_oe` is 0. It stays 0 through no-strobe cycles without a write qualifier until a strobe starts a new read.
- R9: On a read that follows a deselect, `dq_oe` stays 0 after the edge that opens the read and becomes 1 only after the next edge.
- R10: A deselect edge drops `dq_oe` to 0 right after that edge, even when a read was streaming.
- R11: `oe_n`=1 forces `dq_oe` to 0 at once, without a clock edge, and `oe_n`=0 restores it.
- R12: While `rst_n` is low, `dq_oe` is 0 and no burst is open.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ce1_n | input | 1 | Chip enable, active low; also gates the processor strobe |
| ce2 | input | 1 | Chip enable, active high |
| ce3_n | input | 1 | Chip enable, active low |
| adsp_n | input | 1 | Processor address strobe, active low |
| adsc_n | input | 1 | Controller address strobe, active low |
| adv_n | input | 1 | Burst advance, active low |
| gw_n | input | 1 | Global write, active low |
| bwe_n | input | 1 | Byte-write enable, active low |
| bw_n | input | LANES | Lane selects, active low |
| oe_n | input | 1 | Asynchronous output enable, active low |
| order_lin | input | 1 | Burst order: 1 linear, 0 interleaved |
| addr | input | ADDR_W | Word address captured by a strobe |
| wdata | input | LANES*LANE_W | Write data |
| rdata | output | LANES*LANE_W | Registered read data |
| dq_oe | output | 1 | Data bus drive enable |

## Verification
The byte-masked writes are exercised by a table of vectors. It covers a global write with the lane selects idle, single-lane and two-lane selects, an empty select set, the byte-write enable held high, and the global write overriding the lane selects. Each entry is read back, so a wrong lane index, a wrong priority or a leak into an unselected lane shows up as a data mismatch. Directed sequences then try the following:
- the processor strobe with write inputs active, with and without a following write edge, which separates "starts a read" from "writes now";
- both strobes low together;
- the processor strobe while `ce1_n` is high;
- deselects through different enables;
- bursts from a non-zero base in both orders, which separate the wrap arithmetic of the two orders;
- the bus enable edges around writes, deselects and asynchronous output-enable changes.

// File: rtl/sbs_pkg.sv
package sbs_pkg;

  typedef enum logic [2:0] {
    CY_IDLE,
    CY_DESEL,
    CY_RD_NEW,
    CY_WR_NEW,
    CY_RD_CONT,
    CY_WR_CONT
  } cyc_e;

  typedef enum logic [1:0] {
    BK_NONE,
    BK_RD,
    BK_WR
  } bk_e;

  function automatic logic [1:0] burst_lo(input logic [1:0] base,
                                          input logic [1:0] step,
                                          input logic       lin);
    logic [1:0] r;
    if (lin) r = base + step;
    else     r = base ^ step;
    return r;
  endfunction

  function automatic logic cyc_reads(input cyc_e c);
    return (c == CY_RD_NEW) || (c == CY_RD_CONT);
  endfunction

  function automatic logic cyc_writes(input cyc_e c);
    return (c == CY_WR_NEW) || (c == CY_WR_CONT);
  endfunction

  function automatic logic cyc_opens(input cyc_e c);
    return (c == CY_RD_NEW) || (c == CY_WR_NEW);
  endfunction

endpackage

// File: rtl/sbs_cycle_decode.sv
module sbs_cycle_decode
  import sbs_pkg::*;
#(
  parameter int LANES = 4
) (
  input  logic             ce1_n,
  input  logic             ce2,
  input  logic             ce3_n,
  input  logic             adsp_n,
  input  logic             adsc_n,
  input  logic             adv_n,
  input  logic             gw_n,
  input  logic             bwe_n,
  input  logic [LANES-1:0] bw_n,
  input  bk_e              bk,
  output cyc_e             cyc,
  output logic             step,
  output logic [LANES-1:0] lane_sel
);

  logic picked;
  logic p_take;
  logic wq;

  assign picked = !ce1_n && ce2 && !ce3_n;
  assign p_take = !adsp_n && !ce1_n;

  always_comb begin
    if (!gw_n)       lane_sel = '1;
    else if (!bwe_n) lane_sel = ~bw_n;
    else             lane_sel = '0;
  end

  assign wq = |lane_sel;

  always_comb begin
    if (p_take) begin
      cyc = picked ? CY_RD_NEW : CY_DESEL;
    end else if (!adsc_n) begin
      if (!picked)  cyc = CY_DESEL;
      else if (wq)  cyc = CY_WR_NEW;
      else          cyc = CY_RD_NEW;
    end else begin
      case (bk)
        BK_RD:   cyc = wq ? CY_WR_CONT : CY_RD_CONT;
        BK_WR:   cyc = wq ? CY_WR_CONT : CY_IDLE;
        default: cyc = CY_IDLE;
      endcase
    end
  end

  assign step = !adv_n && ((cyc == CY_RD_CONT) || (cyc == CY_WR_CONT));

endmodule

// File: rtl/sbs_burst_seq.sv
module sbs_burst_seq
  import sbs_pkg::*;
#(
  parameter int ADDR_W = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [ADDR_W-1:0] load_addr,
  input  logic              step,
  input  logic              lin,
  output logic [ADDR_W-1:0] cur_addr,
  output logic [ADDR_W-1:0] nxt_addr
);

  logic [ADDR_W-1:0] base_q;
  logic [1:0]        cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      base_q <= '0;
      cnt_q  <= '0;
    end else if (load) begin
      base_q <= load_addr;
      cnt_q  <= '0;
    end else if (step) begin
      cnt_q  <= cnt_q + 2'd1;
    end
  end

  assign cur_addr = {base_q[ADDR_W-1:2], burst_lo(base_q[1:0], cnt_q, lin)};
  assign nxt_addr = {base_q[ADDR_W-1:2], burst_lo(base_q[1:0], cnt_q + 2'd1, lin)};

  // R7: a step always lands on a different word of the same aligned group
  a_r7_step_moves: assert property (@(posedge clk) disable iff (!rst_n)
    (step && !load && $stable(lin)) |=> (cur_addr != $past(cur_addr)) &&
                      (cur_addr[ADDR_W-1:2] == $past(cur_addr[ADDR_W-1:2])));

endmodule

// File: rtl/sbs_lane_array.sv
module sbs_lane_array #(
  parameter int ADDR_W = 6,
  parameter int LANES  = 4,
  parameter int LANE_W = 9
) (
  input  logic                    clk,
  input  logic [LANES-1:0]        we,
  input  logic [ADDR_W-1:0]       waddr,
  input  logic [LANES*LANE_W-1:0] wdata,
  input  logic [ADDR_W-1:0]       raddr,
  output logic [LANES*LANE_W-1:0] rdata
);

  localparam int DEPTH = 1 << ADDR_W;

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    logic [LANE_W-1:0] cells [DEPTH];

    always_ff @(posedge clk) begin
      if (we[g]) cells[waddr] <= wdata[g*LANE_W +: LANE_W];
    end

    assign rdata[g*LANE_W +: LANE_W] = cells[raddr];
  end

endmodule

// File: rtl/burst_sram_core.sv
module burst_sram_core
  import sbs_pkg::*;
#(
  parameter int ADDR_W = 6,
  parameter int LANES  = 4,
  parameter int LANE_W = 9
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    ce1_n,
  input  logic                    ce2,
  input  logic                    ce3_n,
  input  logic                    adsp_n,
  input  logic                    adsc_n,
  input  logic                    adv_n,
  input  logic                    gw_n,
  input  logic                    bwe_n,
  input  logic [LANES-1:0]        bw_n,
  input  logic                    oe_n,
  input  logic                    order_lin,
  input  logic [ADDR_W-1:0]       addr,
  input  logic [LANES*LANE_W-1:0] wdata,
  output logic [LANES*LANE_W-1:0] rdata,
  output logic                    dq_oe
);

  localparam int WORD_W = LANES * LANE_W;

  cyc_e              cyc;
  bk_e               bk_q;
  logic              step;
  logic [LANES-1:0]  lane_sel;
  logic [ADDR_W-1:0] seq_cur;
  logic [ADDR_W-1:0] seq_nxt;
  logic [ADDR_W-1:0] acc_addr;
  logic              is_rd;
  logic              is_wr;
  logic              is_open;
  logic              is_desel;
  logic [LANES-1:0]  lane_we;
  logic              rd_v_q;
  logic [ADDR_W-1:0] rd_a_q;
  logic [WORD_W-1:0] arr_rdata;
  logic [WORD_W-1:0] dout_q;
  logic              drive_q;

  sbs_cycle_decode #(.LANES(LANES)) u_dec (
    .ce1_n   (ce1_n),
    .ce2     (ce2),
    .ce3_n   (ce3_n),
    .adsp_n  (adsp_n),
    .adsc_n  (adsc_n),
    .adv_n   (adv_n),
    .gw_n    (gw_n),
    .bwe_n   (bwe_n),
    .bw_n    (bw_n),
    .bk      (bk_q),
    .cyc     (cyc),
    .step    (step),
    .lane_sel(lane_sel)
  );

  assign is_rd    = cyc_reads(cyc);
  assign is_wr    = cyc_writes(cyc);
  assign is_open  = cyc_opens(cyc);
  assign is_desel = (cyc == CY_DESEL);

  sbs_burst_seq #(.ADDR_W(ADDR_W)) u_seq (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (is_open),
    .load_addr(addr),
    .step     (step),
    .lin      (order_lin),
    .cur_addr (seq_cur),
    .nxt_addr (seq_nxt)
  );

  always_comb begin
    if (is_open)   acc_addr = addr;
    else if (step) acc_addr = seq_nxt;
    else           acc_addr = seq_cur;
  end

  assign lane_we = is_wr ? lane_sel : '0;

  sbs_lane_array #(.ADDR_W(ADDR_W), .LANES(LANES), .LANE_W(LANE_W)) u_arr (
    .clk  (clk),
    .we   (lane_we),
    .waddr(acc_addr),
    .wdata(wdata),
    .raddr(rd_a_q),
    .rdata(arr_rdata)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bk_q <= BK_NONE;
    end else begin
      case (cyc)
        CY_DESEL:              bk_q <= BK_NONE;
        CY_RD_NEW, CY_RD_CONT: bk_q <= BK_RD;
        CY_WR_NEW, CY_WR_CONT: bk_q <= BK_WR;
        default:               bk_q <= bk_q;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_v_q  <= 1'b0;
      rd_a_q  <= '0;
      dout_q  <= '0;
      drive_q <= 1'b0;
    end else begin
      rd_v_q  <= is_rd;
      rd_a_q  <= acc_addr;
      if (rd_v_q) dout_q <= arr_rdata;
      drive_q <= rd_v_q && !is_wr && !is_desel;
    end
  end

  assign rdata = dout_q;
  assign dq_oe = drive_q && !oe_n;

  // R10: a deselect edge leaves the bus undriven
  a_r10_desel_hiz: assert property (@(posedge clk) disable iff (!rst_n)
    is_desel |=> !dq_oe);

  // R8: a write edge leaves the bus undriven
  a_r8_write_hiz: assert property (@(posedge clk) disable iff (!rst_n)
    is_wr |=> !dq_oe);

  // R9: the first read after a deselect is masked for one cycle
  a_r9_first_masked: assert property (@(posedge clk) disable iff (!rst_n)
    (is_desel ##1 is_rd) |=> !dq_oe);

  // R6: the bus is only driven two samples after a read was registered
  a_r6_drive_after_read: assert property (@(posedge clk) disable iff (!rst_n)
    dq_oe |-> $past(is_rd, 2));

  // R3: an accepted processor strobe never writes on its own edge
  a_r3_adsp_reads: assert property (@(posedge clk) disable iff (!rst_n)
    (!adsp_n && !ce1_n && ce2 && !ce3_n) |-> (cyc == CY_RD_NEW) && (lane_we == '0));

  // R5: global write opens every lane of a write cycle
  a_r5_global_all: assert property (@(posedge clk) disable iff (!rst_n)
    (is_wr && !gw_n) |-> (&lane_we));

endmodule

// File: tb/tb_burst_sram_core.sv
module tb_burst_sram_core;

  localparam int CLK_PERIOD = 10;
  localparam int AW = 6;
  localparam int NL = 4;
  localparam int LW = 9;
  localparam int WW = NL * LW;
  localparam int NVEC = 8;

  // vector: [47] gw_n, [46] bwe_n, [45:42] bw_n, [41:36] addr, [35:0] data
  localparam logic [47:0] VT [0:NVEC-1] = '{
    {1'b0, 1'b1, 4'b1111, 6'd3, 36'hAAA_BBB_CCC},
    {1'b1, 1'b0, 4'b1110, 6'd3, 36'h123_456_789},
    {1'b1, 1'b0, 4'b0101, 6'd3, 36'hF0E_D0C_B0A},
    {1'b1, 1'b1, 4'b0000, 6'd3, 36'h000_000_000},
    {1'b1, 1'b0, 4'b1111, 6'd4, 36'h777_777_777},
    {1'b1, 1'b0, 4'b0000, 6'd5, 36'h5A5_A5A_5A5},
    {1'b0, 1'b0, 4'b1111, 6'd6, 36'h0F0_F0F_0F0},
    {1'b1, 1'b0, 4'b1011, 6'd4, 36'hCDE_F01_234}
  };

  logic          clk = 1'b0;
  logic          rst_n;
  logic          ce1_n, ce2, ce3_n, adsp_n, adsc_n, adv_n, gw_n, bwe_n, oe_n, order_lin;
  logic [NL-1:0] bw_n;
  logic [AW-1:0] addr;
  logic [WW-1:0] wdata;
  logic [WW-1:0] rdata;
  logic          dq_oe;

  logic [WW-1:0] mdl [64];
  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  burst_sram_core #(.ADDR_W(AW), .LANES(NL), .LANE_W(LW)) dut (
    .clk(clk), .rst_n(rst_n), .ce1_n(ce1_n), .ce2(ce2), .ce3_n(ce3_n),
    .adsp_n(adsp_n), .adsc_n(adsc_n), .adv_n(adv_n), .gw_n(gw_n), .bwe_n(bwe_n),
    .bw_n(bw_n), .oe_n(oe_n), .order_lin(order_lin), .addr(addr), .wdata(wdata),
    .rdata(rdata), .dq_oe(dq_oe)
  );

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic chk(input bit ok, input string req, input logic [WW-1:0] act,
                     input logic [WW-1:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic idle();
    adsp_n = 1'b1; adsc_n = 1'b1; adv_n = 1'b1;
    gw_n = 1'b1; bwe_n = 1'b1; bw_n = '1;
    ce1_n = 1'b0; ce2 = 1'b1; ce3_n = 1'b0;
  endtask

  // bench model of a write: per bit, the lane is bit/9
  task automatic model_wr(input logic [AW-1:0] a, input logic g, input logic be,
                          input logic [NL-1:0] b, input logic [WW-1:0] d);
    for (int i = 0; i < WW; i++) begin
      if (g == 1'b0 || (be == 1'b0 && b[i / LW] == 1'b0)) mdl[a][i] = d[i];
    end
  endtask

  task automatic do_write(input logic [AW-1:0] a, input logic g, input logic be,
                          input logic [NL-1:0] b, input logic [WW-1:0] d, input bit check);
    idle();
    adsc_n = 1'b0; addr = a; gw_n = g; bwe_n = be; bw_n = b; wdata = d;
    tick();
    model_wr(a, g, be, b, d);
    if (check && (g == 1'b0 || (be == 1'b0 && b != '1)))
      chk(dq_oe === 1'b0, "R8 write edge", {35'd0, dq_oe}, '0);
    idle();
  endtask

  task automatic read_check(input logic [AW-1:0] a, input string req);
    idle();
    adsc_n = 1'b0; addr = a;
    tick();
    idle();
    tick();
    chk(dq_oe === 1'b1 && rdata === mdl[a], req, rdata, mdl[a]);
  endtask

  task automatic burst_check(input logic [AW-1:0] b, input logic lin, input string req);
    logic [AW-1:0] ea;
    order_lin = lin;
    idle();
    adsc_n = 1'b0; addr = b;
    tick();
    idle();
    for (int i = 0; i < 5; i++) begin
      int s;
      s = (i < 3) ? i : 3;
      adv_n = (i < 3) ? 1'b0 : 1'b1;
      tick();
      if (lin) ea = {b[AW-1:2], 2'((int'(b[1:0]) + s) % 4)};
      else     ea = {b[AW-1:2], b[1:0] ^ 2'(s)};
      chk(dq_oe === 1'b1 && rdata === mdl[ea], req, rdata, mdl[ea]);
    end
    idle();
  endtask

  initial begin
    #(CLK_PERIOD * 20000);
    if (!done) begin
      n_fail++;
      $display("FAIL R12 watchdog actual=hung expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; oe_n = 1'b0; order_lin = 1'b1; addr = '0; wdata = '0;
    idle();
    tick();
    chk(dq_oe === 1'b0, "R12 reset", {35'd0, dq_oe}, '0);
    tick();
    rst_n = 1'b1;
    tick();
    chk(dq_oe === 1'b0, "R12 no burst after reset", {35'd0, dq_oe}, '0);

    for (int a = 0; a < 16; a++)
      do_write(AW'(a), 1'b0, 1'b1, '1, 36'h5A5A5A5A5 ^ (36'(a) * 36'h010203041), 1'b0);

    // R5 / R4: lane-mask table, each vector written by controller strobe then read back
    for (int v = 0; v < NVEC; v++) begin
      do_write(VT[v][41:36], VT[v][47], VT[v][46], VT[v][45:42], VT[v][35:0], 1'b1);
      read_check(VT[v][41:36], "R5 R4 R6 lane mask readback");
    end

    // R3: processor strobe with write inputs active writes nothing on its edge
    read_check(2, "R6 prior read");
    idle();
    adsp_n = 1'b0; addr = 6'd8; gw_n = 1'b0; wdata = 36'hDEAD_BEEF_1;
    tick();
    idle();
    tick();
    chk(dq_oe === 1'b1 && rdata === mdl[8], "R3 adsp ignores write", rdata, mdl[8]);

    // R3 / R8: processor strobe then write on the following edge
    idle();
    adsp_n = 1'b0; addr = 6'd9; gw_n = 1'b0; wdata = 36'h111_111_111;
    tick();
    idle();
    gw_n = 1'b0; wdata = 36'h9AB_CDE_F12;
    tick();
    model_wr(6'd9, 1'b0, 1'b1, '1, 36'h9AB_CDE_F12);
    chk(dq_oe === 1'b0, "R8 after follow-on write", {35'd0, dq_oe}, '0);
    idle();
    tick();
    chk(dq_oe === 1'b0, "R8 stays undriven", {35'd0, dq_oe}, '0);
    read_check(9, "R3 follow-on write data");

    // R4: both strobes low -> processor strobe wins, no write
    idle();
    adsp_n = 1'b0; adsc_n = 1'b0; addr = 6'd10; gw_n = 1'b0; wdata = 36'h0;
    tick();
    idle();
    tick();
    chk(dq_oe === 1'b1 && rdata === mdl[10], "R4 processor strobe wins", rdata, mdl[10]);

    // R2: processor strobe ignored while ce1_n is high
    read_check(5, "R6 read before ignored strobe");
    idle();
    adsp_n = 1'b0; ce1_n = 1'b1; addr = 6'd11;
    tick();
    chk(dq_oe === 1'b1 && rdata === mdl[5], "R2 ignored strobe keeps burst", rdata, mdl[5]);
    idle();
    tick();
    chk(dq_oe === 1'b1 && rdata === mdl[5], "R2 address not captured", rdata, mdl[5]);

    // R10 / R1: deselect through ce2 while streaming, with a global write present
    read_check(2, "R6 read before deselect");
    idle();
    ce2 = 1'b0; adsc_n = 1'b0; addr = 6'd7; gw_n = 1'b0; wdata = 36'hBAD_BAD_BAD;
    tick();
    chk(dq_oe === 1'b0, "R10 deselect drops bus", {35'd0, dq_oe}, '0);
    idle();
    tick();

    // R9: first read after deselect is masked one cycle
    adsc_n = 1'b0; addr = 6'd7;
    tick();
    chk(dq_oe === 1'b0, "R9 first read cycle masked", {35'd0, dq_oe}, '0);
    idle();
    tick();
    chk(dq_oe === 1'b1 && rdata === mdl[7], "R1 deselected write ignored", rdata, mdl[7]);

    // R2 / R1: both strobes low with ce1_n high -> deselect
    idle();
    ce1_n = 1'b1; adsp_n = 1'b0; adsc_n = 1'b0; addr = 6'd1;
    tick();
    chk(dq_oe === 1'b0, "R2 R1 deselect via ce1_n", {35'd0, dq_oe}, '0);
    idle();
    ce3_n = 1'b1; adsc_n = 1'b0; gw_n = 1'b0; addr = 6'd1; wdata = '0;
    tick();
    idle();
    tick();
    read_check(1, "R1 ce3_n deselect ignored write");

    // R7: bursts in both orders from non-zero bases
    burst_check(6'd10, 1'b1, "R7 linear burst wrap");
    burst_check(6'd13, 1'b0, "R7 interleaved burst");
    burst_check(6'd7, 1'b0, "R7 interleaved base 3");

    // R7 / R8: write burst through advance
    order_lin = 1'b1;
    do_write(6'd12, 1'b0, 1'b1, '1, 36'h100_200_300, 1'b1);
    adv_n = 1'b0; gw_n = 1'b0; wdata = 36'h400_500_600;
    tick();
    model_wr(6'd13, 1'b0, 1'b1, '1, 36'h400_500_600);
    adv_n = 1'b0; gw_n = 1'b1; bwe_n = 1'b0; bw_n = 4'b0111; wdata = 36'h700_800_900;
    tick();
    model_wr(6'd14, 1'b1, 1'b0, 4'b0111, 36'h700_800_900);
    idle();
    tick();
    chk(dq_oe === 1'b0, "R8 idle after write burst", {35'd0, dq_oe}, '0);
    read_check(12, "R7 write burst word 0");
    read_check(13, "R7 write burst word 1");
    read_check(14, "R7 R5 write burst word 2");

    // R11: asynchronous output enable
    #1 oe_n = 1'b1;
    #1 chk(dq_oe === 1'b0, "R11 oe_n high", {35'd0, dq_oe}, '0);
    oe_n = 1'b0;
    #1 chk(dq_oe === 1'b1, "R11 oe_n low", {35'd0, dq_oe}, 36'd1);

    // R12: reset mid stream
    rst_n = 1'b0;
    #1 chk(dq_oe === 1'b0, "R12 reset mid stream", {35'd0, dq_oe}, '0);
    tick();
    rst_n = 1'b1;
    idle();
    tick();
    chk(dq_oe === 1'b0, "R12 no burst after release", {35'd0, dq_oe}, '0);

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule